// File: doc/BRIEF.md
# Charge Safety Timer with Slowdown

This block guards a battery charger against a phase that never finishes. It counts one-second ticks while the charger is in pre-charge or fast charge, and it compares the count against a limit that depends on the phase. Pre-charge has a fixed two-hour limit. Fast charge has a limit of either ten or twenty hours, chosen by a configuration bit. When the limit is reached the block latches a timer-expiry fault code.

While the input path is current- or voltage-limited, in thermal regulation, or in a cool or warm temperature zone, the charge current is reduced. To allow for this, the timer can be set to run at half speed under those conditions. No slowdown applies in a temperature zone whose current setting is full current.

After charge termination, a separate top-off timer runs for a selectable number of quarter-hours. It raises an active flag while it counts. Deciding the charge phase is the job of another block: this block takes the phase as an input.

Top module: `chg_safety_timer`

## Requirements
- R1: After reset, `fault_code_o` is 00, and `timer_run_o` and `topoff_active_o` are low.
- R2: Phase encoding on `phase_i` is 00 idle, 01 pre-charge, 10 fast, 11 terminated. In pre-charge with the timer enabled, `fault_code_o` becomes 11 at the clock edge that samples the 2*SEC_PER_HOUR-th counted tick, and not before.
- R3: In fast charge, the limit is 10*SEC_PER_HOUR ticks when `fast_short_i` is 1 and 20*SEC_PER_HOUR ticks when it is 0.
- R4: While `timer_en_i` is 0, nothing is counted, no fault is raised and `timer_run_o` is low.
- R5: When `slow_en_i` is 1 and any slowdown cause holds, the ticks alternate between skipped and counted, starting with a skip, so the limit takes twice as many ticks. The causes are `iin_lim_i`, `vin_lim_i`, `therm_reg_i`, `cool_zone_i` with `cool_iset_i` not 11, and `warm_zone_i` with `warm_iset_i` not 11.
- R6: A temperature zone whose current setting is 11 (full current) causes no slowdown, and with `slow_en_i` at 0 no cause slows the timer.
- R7: Any change of `phase_i` restarts the safety count from zero. A tick in the cycle of the change is not counted.
- R8: An expiry fault stays latched across changes between active phases until `phase_i` is idle or a register reset occurs. `timer_run_o` is low while the fault is set.
- R9: A one-cycle `reg_rst_i` clears the fault, the safety count and the top-off count. In an unchanged active phase, counting then restarts from zero.
- R10: In the terminated phase with `topoff_sel_i` equal to 01, 10 or 11, `topoff_active_o` is high until 1, 2 or 3 times SEC_PER_QTR ticks have been counted. With 00 it is never high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse per second |
| phase_i | input | 2 | Charge phase: 00 idle, 01 pre, 10 fast, 11 terminated |
| timer_en_i | input | 1 | Enables both safety timers |
| fast_short_i | input | 1 | Fast-charge limit: 1 = 10 h, 0 = 20 h |
| slow_en_i | input | 1 | Enables half-speed counting under slowdown causes |
| iin_lim_i | input | 1 | Input current limiting active |
| vin_lim_i | input | 1 | Input voltage limiting active |
| therm_reg_i | input | 1 | Thermal regulation active |
| cool_zone_i | input | 1 | Battery in cool zone |
| cool_iset_i | input | 2 | Cool-zone current setting, 11 = full current |
| warm_zone_i | input | 1 | Battery in warm zone |
| warm_iset_i | input | 2 | Warm-zone current setting, 11 = full current |
| topoff_sel_i | input | 2 | Top-off length in quarter-hours, 00 = off |
| reg_rst_i | input | 1 | Register reset pulse |
| fault_code_o | output | 2 | 11 on safety timer expiry, else 00 |
| timer_run_o | output | 1 | Safety timer is counting |
| topoff_active_o | output | 1 | Top-off timer is counting |

## Verification
A count that is off by even one shows up as a fault edge one tick early or late, so the bench samples the fault at the tick just before the limit and at the limit itself. A half-rate toggle that is wrong at the start of slowdown makes the expiry arrive one tick early. A slowdown cause that is decoded wrongly moves the expiry by a whole limit's worth of ticks. A fault latch that clears on the wrong condition shows within one clock cycle of a phase change or a register reset.

// File: rtl/chg_tmr_pkg.sv
package chg_tmr_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_PRE  = 2'b01,
    PH_FAST = 2'b10,
    PH_TERM = 2'b11
  } chg_phase_e;

  localparam logic [1:0] FLT_NONE  = 2'b00;
  localparam logic [1:0] FLT_TIMER = 2'b11;
  localparam logic [1:0] ISET_FULL = 2'b11;

  localparam int unsigned PRE_HOURS        = 2;
  localparam int unsigned FAST_SHORT_HOURS = 10;
  localparam int unsigned FAST_LONG_HOURS  = 20;
  localparam int unsigned TOPOFF_MAX_QTR   = 3;
endpackage

// File: rtl/chg_slow_gate.sv
module chg_slow_gate
  import chg_tmr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       restart_i,
  input  logic       slow_en_i,
  input  logic       iin_lim_i,
  input  logic       vin_lim_i,
  input  logic       therm_reg_i,
  input  logic       cool_zone_i,
  input  logic [1:0] cool_iset_i,
  input  logic       warm_zone_i,
  input  logic [1:0] warm_iset_i,
  output logic       adv_o
);
  logic cool_slow, warm_slow, slow;
  logic half_q;

  // a zone at full current never slows the timer
  assign cool_slow = cool_zone_i && (cool_iset_i != ISET_FULL);
  assign warm_slow = warm_zone_i && (warm_iset_i != ISET_FULL);
  assign slow      = slow_en_i && (iin_lim_i || vin_lim_i || therm_reg_i || cool_slow || warm_slow);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                half_q <= 1'b0;
    else if (restart_i || !slow) half_q <= 1'b0;
    else if (tick_i)            half_q <= ~half_q;
  end

  // under slowdown the first tick is skipped, then every other tick counts
  assign adv_o = tick_i && (!slow || half_q);
endmodule

// File: rtl/chg_safety_cnt.sv
module chg_safety_cnt
  import chg_tmr_pkg::*;
#(
  parameter int unsigned SEC_PER_HOUR = 3600
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  input  logic active_i,
  input  logic is_fast_i,
  input  logic fast_short_i,
  input  logic restart_i,
  input  logic clear_flt_i,
  output logic expired_o
);
  localparam int unsigned CNT_W = $clog2(FAST_LONG_HOURS * SEC_PER_HOUR + 1);
  localparam logic [CNT_W-1:0] LIM_PRE   = CNT_W'(PRE_HOURS * SEC_PER_HOUR);
  localparam logic [CNT_W-1:0] LIM_SHORT = CNT_W'(FAST_SHORT_HOURS * SEC_PER_HOUR);
  localparam logic [CNT_W-1:0] LIM_LONG  = CNT_W'(FAST_LONG_HOURS * SEC_PER_HOUR);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;
  logic [CNT_W:0]   cnt_nxt;
  logic             exp_q;
  logic             step;

  always_comb begin
    if (!is_fast_i)       limit = LIM_PRE;
    else if (fast_short_i) limit = LIM_SHORT;
    else                  limit = LIM_LONG;
  end

  assign cnt_nxt = {1'b0, cnt_q} + (CNT_W+1)'(1);
  assign step    = active_i && !restart_i && adv_i && !exp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else begin
      if (restart_i || !active_i) cnt_q <= '0;
      else if (step)              cnt_q <= cnt_nxt[CNT_W-1:0];

      if (clear_flt_i)                               exp_q <= 1'b0;
      else if (step && (cnt_nxt >= {1'b0, limit}))   exp_q <= 1'b1;
    end
  end

  assign expired_o = exp_q;
endmodule

// File: rtl/chg_topoff_cnt.sv
module chg_topoff_cnt
  import chg_tmr_pkg::*;
#(
  parameter int unsigned SEC_PER_QTR = 900
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       in_term_i,
  input  logic       restart_i,
  input  logic [1:0] sel_i,
  output logic       active_o
);
  localparam int unsigned TW = $clog2(TOPOFF_MAX_QTR * SEC_PER_QTR + 1);

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] limit;
  logic [TW:0]   cnt_nxt;
  logic          done_q;
  logic          on;

  always_comb begin
    case (sel_i)
      2'b01:   limit = TW'(SEC_PER_QTR);
      2'b10:   limit = TW'(2 * SEC_PER_QTR);
      2'b11:   limit = TW'(3 * SEC_PER_QTR);
      default: limit = '0;
    endcase
  end

  assign on      = in_term_i && (sel_i != 2'b00);
  assign cnt_nxt = {1'b0, cnt_q} + (TW+1)'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (restart_i || !on) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (tick_i && !done_q) begin
      cnt_q <= cnt_nxt[TW-1:0];
      if (cnt_nxt >= {1'b0, limit}) done_q <= 1'b1;
    end
  end

  assign active_o = on && !done_q;
endmodule

// File: rtl/chg_safety_timer.sv
module chg_safety_timer
  import chg_tmr_pkg::*;
#(
  parameter int unsigned SEC_PER_HOUR = 3600,
  parameter int unsigned SEC_PER_QTR  = 900
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic [1:0] phase_i,
  input  logic       timer_en_i,
  input  logic       fast_short_i,
  input  logic       slow_en_i,
  input  logic       iin_lim_i,
  input  logic       vin_lim_i,
  input  logic       therm_reg_i,
  input  logic       cool_zone_i,
  input  logic [1:0] cool_iset_i,
  input  logic       warm_zone_i,
  input  logic [1:0] warm_iset_i,
  input  logic [1:0] topoff_sel_i,
  input  logic       reg_rst_i,
  output logic [1:0] fault_code_o,
  output logic       timer_run_o,
  output logic       topoff_active_o
);
  chg_phase_e phase, phase_q;
  logic restart, active, clear_flt, adv, expired;

  assign phase = chg_phase_e'(phase_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_IDLE;
    else         phase_q <= phase;
  end

  assign restart   = (phase != phase_q) || reg_rst_i;
  assign active    = timer_en_i && ((phase == PH_PRE) || (phase == PH_FAST));
  assign clear_flt = reg_rst_i || (phase == PH_IDLE);

  chg_slow_gate u_slow (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .restart_i   (restart),
    .slow_en_i   (slow_en_i),
    .iin_lim_i   (iin_lim_i),
    .vin_lim_i   (vin_lim_i),
    .therm_reg_i (therm_reg_i),
    .cool_zone_i (cool_zone_i),
    .cool_iset_i (cool_iset_i),
    .warm_zone_i (warm_zone_i),
    .warm_iset_i (warm_iset_i),
    .adv_o       (adv)
  );

  chg_safety_cnt #(.SEC_PER_HOUR(SEC_PER_HOUR)) u_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .adv_i        (adv),
    .active_i     (active),
    .is_fast_i    (phase == PH_FAST),
    .fast_short_i (fast_short_i),
    .restart_i    (restart),
    .clear_flt_i  (clear_flt),
    .expired_o    (expired)
  );

  chg_topoff_cnt #(.SEC_PER_QTR(SEC_PER_QTR)) u_topoff (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .in_term_i (phase == PH_TERM),
    .restart_i (restart),
    .sel_i     (topoff_sel_i),
    .active_o  (topoff_active_o)
  );

  assign fault_code_o = expired ? FLT_TIMER : FLT_NONE;
  assign timer_run_o  = active && !expired;
endmodule

// File: rtl/chg_safety_timer_chk.sv
module chg_safety_timer_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic [1:0] phase_i,
  input logic       timer_en_i,
  input logic       reg_rst_i,
  input logic [1:0] fault_code_o,
  input logic       timer_run_o,
  input logic       topoff_active_o
);
  p_fault_on_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_code_o[1]) |-> ($past(tick_i) && $past(timer_en_i)));

  p_no_run_disabled_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !timer_en_i |-> !timer_run_o);

  p_idle_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == 2'b00) |=> (fault_code_o == 2'b00));

  p_fault_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((fault_code_o == 2'b11) && (phase_i != 2'b00) && !reg_rst_i) |=> (fault_code_o == 2'b11));

  p_run_excl_fault_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timer_run_o |-> (fault_code_o == 2'b00));

  p_reg_rst_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rst_i |=> ((fault_code_o == 2'b00) && (!topoff_active_o || (phase_i == 2'b11))));

  p_topoff_term_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    topoff_active_o |-> (phase_i == 2'b11));
endmodule

bind chg_safety_timer chg_safety_timer_chk u_chk (.*);

// File: tb/chg_safety_timer_tb_top.sv
`timescale 1ns/1ps
module chg_safety_timer_tb_top;
  localparam int H = 8;
  localparam int Q = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick = 1'b0;
  logic [1:0] phase = 2'b00;
  logic en = 1'b0, fshort = 1'b1, slow_en = 1'b0;
  logic iin = 1'b0, vin = 1'b0, therm = 1'b0, cool = 1'b0, warm = 1'b0;
  logic [1:0] cool_iset = 2'b01, warm_iset = 2'b11, tsel = 2'b00;
  logic reg_rst = 1'b0;
  logic [1:0] fault;
  logic run, tact;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  chg_safety_timer #(.SEC_PER_HOUR(H), .SEC_PER_QTR(Q)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .phase_i(phase),
    .timer_en_i(en), .fast_short_i(fshort), .slow_en_i(slow_en),
    .iin_lim_i(iin), .vin_lim_i(vin), .therm_reg_i(therm),
    .cool_zone_i(cool), .cool_iset_i(cool_iset), .warm_zone_i(warm),
    .warm_iset_i(warm_iset), .topoff_sel_i(tsel), .reg_rst_i(reg_rst),
    .fault_code_o(fault), .timer_run_o(run), .topoff_active_o(tact)
  );

  function automatic int lim_ticks(logic [1:0] ph, logic short_sel, bit slowed);
    int base;
    base = (ph == 2'b01) ? 2 * H : (short_sel ? 10 * H : 20 * H);
    return slowed ? 2 * base : base;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic set_phase(logic [1:0] p);
    @(negedge clk); phase = p;
    @(negedge clk);
  endtask

  task automatic clear_causes();
    iin = 0; vin = 0; therm = 0; cool = 0; warm = 0;
    cool_iset = 2'b01; warm_iset = 2'b01;
  endtask

  task automatic pulse_rst();
    @(negedge clk); reg_rst = 1'b1;
    @(negedge clk); reg_rst = 1'b0;
  endtask

  // run to one tick before the limit, then to the limit
  task automatic run_limit(string req, int n);
    ticks(n - 1);
    chk({req, " before limit fault"}, fault, 0);
    chk({req, " before limit run"}, run, 1);
    ticks(1);
    chk({req, " at limit fault"}, fault, 3);
    chk({req, " at limit run"}, run, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20241));
    repeat (3) @(negedge clk);
    chk("R1 fault", fault, 0);
    chk("R1 run", run, 0);
    chk("R1 topoff", tact, 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R2 pre-charge limit
    en = 1;
    set_phase(2'b01);
    run_limit("R2 pre", lim_ticks(2'b01, 1, 0));

    // R8 idle clears fault
    set_phase(2'b00);
    chk("R8 idle clears", fault, 0);

    // R3 fast limits
    fshort = 1; set_phase(2'b10);
    run_limit("R3 fast short", lim_ticks(2'b10, 1, 0));
    set_phase(2'b00);
    fshort = 0; set_phase(2'b10);
    run_limit("R3 fast long", lim_ticks(2'b10, 0, 0));
    set_phase(2'b00);

    // R4 disabled
    en = 0; fshort = 1; set_phase(2'b01);
    ticks(3 * H);
    chk("R4 disabled fault", fault, 0);
    chk("R4 disabled run", run, 0);
    set_phase(2'b00);
    en = 1;

    // R6 full-current zones and slow_en off do not slow
    slow_en = 1; cool = 1; cool_iset = 2'b11; warm = 1; warm_iset = 2'b11;
    set_phase(2'b01);
    run_limit("R6 full iset", lim_ticks(2'b01, 1, 0));
    set_phase(2'b00); clear_causes();
    slow_en = 0; iin = 1; therm = 1;
    set_phase(2'b01);
    run_limit("R6 slow_en off", lim_ticks(2'b01, 1, 0));
    set_phase(2'b00); clear_causes();

    // R5 random slowdown mix
    for (int it = 0; it < 14; it++) begin
      logic [1:0] ph;
      int src;
      bit sl;
      ph = ($urandom_range(0, 1) == 0) ? 2'b01 : 2'b10;
      fshort = 1'($urandom_range(0, 1));
      slow_en = 1'($urandom_range(0, 3) != 0);
      src = $urandom_range(0, 5);
      case (src)
        0: iin = 1;
        1: vin = 1;
        2: therm = 1;
        3: begin cool = 1; cool_iset = 2'($urandom_range(0, 2)); end
        4: begin warm = 1; warm_iset = 2'($urandom_range(0, 2)); end
        default: begin cool = 1; cool_iset = 2'b11; end
      endcase
      sl = slow_en && (src != 5);
      set_phase(ph);
      run_limit("R5 random", lim_ticks(ph, fshort, sl));
      set_phase(2'b00);
      clear_causes();
    end
    slow_en = 0;

    // R7 restart on phase change, R8 sticky across active phases
    fshort = 1;
    set_phase(2'b01);
    ticks(10);
    set_phase(2'b10);
    run_limit("R7 restart", lim_ticks(2'b10, 1, 0));
    set_phase(2'b01);
    chk("R8 sticky fault", fault, 3);
    chk("R8 run low", run, 0);

    // R9 register reset
    pulse_rst();
    chk("R9 fault cleared", fault, 0);
    run_limit("R9 recount", lim_ticks(2'b01, 1, 0));
    set_phase(2'b00);

    // R10 top-off
    tsel = 2'b01; set_phase(2'b11);
    chk("R10 sel1 start", tact, 1);
    ticks(Q - 1);
    chk("R10 sel1 running", tact, 1);
    ticks(1);
    chk("R10 sel1 done", tact, 0);
    set_phase(2'b00);
    tsel = 2'b11; set_phase(2'b11);
    ticks(3 * Q - 1);
    chk("R10 sel3 running", tact, 1);
    ticks(1);
    chk("R10 sel3 done", tact, 0);
    set_phase(2'b00);
    tsel = 2'b00; set_phase(2'b11);
    chk("R10 sel0 off", tact, 0);
    ticks(2);
    chk("R10 sel0 still off", tact, 0);
    set_phase(2'b00);

    // R9 register reset restarts top-off
    tsel = 2'b10; set_phase(2'b11);
    ticks(2 * Q - 1);
    pulse_rst();
    ticks(2 * Q - 1);
    chk("R9 topoff restarted", tact, 1);
    ticks(1);
    chk("R9 topoff done", tact, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule